// File: doc/BRIEF.md
# Interrupt Message Generator with Legacy and Message-Signalled Modes

The block turns per-vector interrupt request lines from device logic into outbound interrupt messages on a single valid/ready channel. Three signalling schemes are available. With both message enables clear, the vectors are folded onto four level-sensitive legacy lines, and every level change of a line goes out as a virtual-wire assert or deassert message. With the single-address message mode enabled, each request becomes a memory write to one programmed address, and the vector number is carried in the low bits of the data word. With the table mode enabled, each vector has its own address, data and mask entry, loaded through a write port.

Device logic holds a vector request line high for as long as its legacy level is wanted. In either message mode, a rising edge on a request line records one pending message for that vector. Packet framing and arbitration with other traffic belong to the consumer of the message channel.

Top module: `irq_msg_gen`

## Requirements
- R1: While reset is asserted and after it is released with no request, `msg_valid_o` is low and no message is offered.
- R2: With both enables clear, legacy line k (0..3) is the OR of every vector v with v mod 4 = k. A rise of a line produces one message of type 0 (assert), and a fall produces one message of type 1 (deassert). Both carry address 0 and data k. A change in a vector whose line level stays the same produces no message.
- R3: A deassert message is produced only for a line whose assert message was sent earlier. Enabling a message mode while no line is asserted produces no message.
- R4: While either message enable is set, no assert message is produced and legacy level changes produce no message.
- R5: When a message mode is enabled while legacy lines are asserted, a deassert message for each such line is produced before any memory-write message. This holds even when a vector request rises in the same cycle as the enable.
- R6: In single-address mode (`msi_en_i`=1, `msix_en_i`=0), a request rise on vector v produces a message of type 2 (memory write). Its address is `msi_addr_i`. Its data is `msi_data_i` with the low log2(NVEC) bits replaced by v.
- R7: In table mode (`msix_en_i`=1, with either value of `msi_en_i`), a request rise on vector v produces a type-2 message carrying the address and data last written to table entry v.
- R8: While the mask bit of table entry v is set in table mode, the request for v stays pending and is not sent. It is sent once the mask bit is cleared. Other vectors are not held back. Every mask bit is set after reset.
- R9: When several vectors or legacy lines need a message at the same time, the lowest-numbered one is sent first.
- R10: A message offered with `msg_valid_o` high stays offered with unchanged type, address and data until `msg_ready_i` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_req_i | input | NVEC | Per-vector request levels |
| msi_en_i | input | 1 | Single-address message mode enable |
| msix_en_i | input | 1 | Per-vector table mode enable (wins over msi_en_i) |
| msi_addr_i | input | AW | Common message address |
| msi_data_i | input | DW | Common message data base value |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | VW | Table entry index to write |
| tbl_addr_i | input | AW | Address field written into the entry |
| tbl_data_i | input | DW | Data field written into the entry |
| tbl_mask_i | input | 1 | Mask bit written into the entry |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Consumer accepts the offered message |
| msg_type_o | output | 2 | 0 assert, 1 deassert, 2 memory write |
| msg_addr_o | output | AW | Message address |
| msg_data_o | output | DW | Message data (legacy line number for types 0 and 1) |

## Verification
The legacy teardown on a mode switch and a fresh message request can land in the same cycle. The bench provokes this by raising the single-address enable and a vector request on the same edge while two legacy lines are asserted and the consumer is stalled. It then requires exactly two deasserts in line order followed by one memory write. Seeded random vector bursts under random backpressure then check ascending service order, the field values and the hold of stalled messages in both message modes.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    typedef enum logic [1:0] {
        MSG_ASSERT   = 2'd0,
        MSG_DEASSERT = 2'd1,
        MSG_MEMWR    = 2'd2
    } msg_kind_e;

endpackage

// File: rtl/irq_legacy_track.sv
module irq_legacy_track #(
    parameter int NVEC  = 8,
    parameter int NLINE = 4,
    localparam int LW   = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NVEC-1:0]  vec_lvl,
    input  logic             msg_mode,
    input  logic             take,
    output logic             need,
    output logic [LW-1:0]    line_idx,
    output logic             is_assert,
    output logic [NLINE-1:0] sent
);

    logic [NLINE-1:0] sent_d, sent_q;
    logic [NLINE-1:0] level, desired, diff;

    always_comb begin
        level = '0;
        for (int k = 0; k < NLINE; k++) begin
            for (int v = 0; v < NVEC; v++) begin
                if ((v % NLINE) == k) level[k] = level[k] | vec_lvl[v];
            end
        end
        desired  = msg_mode ? '0 : level;
        diff     = desired ^ sent_q;
        need     = |diff;
        line_idx = '0;
        for (int k = NLINE - 1; k >= 0; k--) begin
            if (diff[k]) line_idx = LW'(k);
        end
        is_assert = desired[line_idx];
        sent_d    = sent_q;
        if (take && need) sent_d[line_idx] = desired[line_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sent_q <= '0;
        else        sent_q <= sent_d;
    end

    assign sent = sent_q;

    AST_NO_ASSERT_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sent_q & ~$past(sent_q))) |-> !$past(msg_mode)); // R4

endmodule

// File: rtl/irq_vec_pending.sv
module irq_vec_pending #(
    parameter int NVEC = 8,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] vec_req,
    input  logic            msg_mode,
    input  logic [NVEC-1:0] blocked,
    input  logic            take,
    output logic            any,
    output logic [VW-1:0]   idx
);

    typedef struct packed {
        logic [NVEC-1:0] prev;
        logic [NVEC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [NVEC-1:0] elig, rise, clr;

    always_comb begin
        elig = st_q.pend & ~blocked;
        any  = |elig;
        idx  = '0;
        for (int v = NVEC - 1; v >= 0; v--) begin
            if (elig[v]) idx = VW'(v);
        end
        rise = vec_req & ~st_q.prev;
        clr  = '0;
        if (take && any) clr[idx] = 1'b1;
        st_d.prev = vec_req;
        st_d.pend = msg_mode ? ((st_q.pend & ~clr) | rise) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_msix_table.sv
module irq_msix_table #(
    parameter int NVEC = 8,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [VW-1:0]   wr_idx,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            wr_mask,
    input  logic [VW-1:0]   rd_idx,
    output logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [NVEC-1:0] mask_vec
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          mask;
    } entry_t;

    entry_t [NVEC-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en && (int'(wr_idx) < NVEC)) begin
            tab_d[wr_idx] = '{addr: wr_addr, data: wr_data, mask: wr_mask};
        end
        for (int v = 0; v < NVEC; v++) mask_vec[v] = tab_q[v].mask;
        rd_addr = tab_q[rd_idx].addr;
        rd_data = tab_q[rd_idx].data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NVEC; v++) tab_q[v] <= '{addr: '0, data: '0, mask: 1'b1};
        end else begin
            tab_q <= tab_d;
        end
    end

endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
    import irq_msg_pkg::*;
#(
    parameter int NVEC  = 8,
    parameter int NLINE = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int VW   = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int LW   = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] vec_req_i,
    input  logic            msi_en_i,
    input  logic            msix_en_i,
    input  logic [AW-1:0]   msi_addr_i,
    input  logic [DW-1:0]   msi_data_i,
    input  logic            tbl_we_i,
    input  logic [VW-1:0]   tbl_idx_i,
    input  logic [AW-1:0]   tbl_addr_i,
    input  logic [DW-1:0]   tbl_data_i,
    input  logic            tbl_mask_i,
    output logic            msg_valid_o,
    input  logic            msg_ready_i,
    output logic [1:0]      msg_type_o,
    output logic [AW-1:0]   msg_addr_o,
    output logic [DW-1:0]   msg_data_o
);

    localparam logic [DW-1:0] VEC_FIELD = {{(DW-VW){1'b0}}, {VW{1'b1}}};

    typedef struct packed {
        logic          valid;
        msg_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } out_t;

    out_t out_d, out_q;

    logic             msg_mode, load, leg_take, msi_take;
    logic             leg_need, leg_assert;
    logic [LW-1:0]    leg_line;
    logic [NLINE-1:0] leg_sent;
    logic             pend_any;
    logic [VW-1:0]    pend_idx;
    logic [NVEC-1:0]  tbl_mask, blocked;
    logic [AW-1:0]    tbl_addr;
    logic [DW-1:0]    tbl_data;

    assign msg_mode = msi_en_i | msix_en_i;
    assign blocked  = msix_en_i ? tbl_mask : '0;

    irq_legacy_track #(.NVEC(NVEC), .NLINE(NLINE)) u_legacy (
        .clk(clk), .rst_n(rst_n), .vec_lvl(vec_req_i), .msg_mode(msg_mode),
        .take(leg_take), .need(leg_need), .line_idx(leg_line),
        .is_assert(leg_assert), .sent(leg_sent)
    );

    irq_vec_pending #(.NVEC(NVEC)) u_pending (
        .clk(clk), .rst_n(rst_n), .vec_req(vec_req_i), .msg_mode(msg_mode),
        .blocked(blocked), .take(msi_take), .any(pend_any), .idx(pend_idx)
    );

    irq_msix_table #(.NVEC(NVEC), .AW(AW), .DW(DW)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we_i), .wr_idx(tbl_idx_i),
        .wr_addr(tbl_addr_i), .wr_data(tbl_data_i), .wr_mask(tbl_mask_i),
        .rd_idx(pend_idx), .rd_addr(tbl_addr), .rd_data(tbl_data), .mask_vec(tbl_mask)
    );

    always_comb begin
        load     = !out_q.valid || msg_ready_i;
        leg_take = load && leg_need;
        msi_take = load && !leg_need && (leg_sent == '0) && msg_mode && pend_any;
        out_d    = out_q;
        if (leg_take) begin
            out_d.valid = 1'b1;
            out_d.kind  = leg_assert ? MSG_ASSERT : MSG_DEASSERT;
            out_d.addr  = '0;
            out_d.data  = {{(DW-LW){1'b0}}, leg_line};
        end else if (msi_take) begin
            out_d.valid = 1'b1;
            out_d.kind  = MSG_MEMWR;
            if (msix_en_i) begin
                out_d.addr = tbl_addr;
                out_d.data = tbl_data;
            end else begin
                out_d.addr = msi_addr_i;
                out_d.data = (msi_data_i & ~VEC_FIELD) | {{(DW-VW){1'b0}}, pend_idx};
            end
        end else if (load) begin
            out_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{valid: 1'b0, kind: MSG_ASSERT, addr: '0, data: '0};
        else        out_q <= out_d;
    end

    assign msg_valid_o = out_q.valid;
    assign msg_type_o  = out_q.kind;
    assign msg_addr_o  = out_q.addr;
    assign msg_data_o  = out_q.data;

    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_type_o)
            && $stable(msg_addr_o) && $stable(msg_data_o))); // R10

    AST_MEMWR_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && msg_type_o == MSG_MEMWR) |-> (leg_sent == '0)); // R5

    AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_take && msix_en_i) |-> !tbl_mask[pend_idx]); // R8

    AST_LEGACY_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && msg_type_o != MSG_MEMWR) |-> (msg_addr_o == '0 && msg_data_o < NLINE)); // R2

endmodule

// File: tb/tb_irq_msg_gen.sv
module tb_irq_msg_gen;

    localparam int NVEC = 8;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int VW   = 3;
    localparam logic [AW-1:0] MSI_ADDR = 32'hFEE0_1000;
    localparam logic [DW-1:0] MSI_DATA = 32'h1234_567D;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NVEC-1:0] vec_req = '0;
    logic            msi_en = 1'b0, msix_en = 1'b0;
    logic            tbl_we = 1'b0, tbl_mask = 1'b0;
    logic [VW-1:0]   tbl_idx = '0;
    logic [AW-1:0]   tbl_addr = '0;
    logic [DW-1:0]   tbl_data = '0;
    logic            msg_valid, msg_ready = 1'b0;
    logic [1:0]      msg_type;
    logic [AW-1:0]   msg_addr;
    logic [DW-1:0]   msg_data;

    always #10 clk = ~clk;

    irq_msg_gen #(.NVEC(NVEC), .NLINE(4), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .vec_req_i(vec_req), .msi_en_i(msi_en),
        .msix_en_i(msix_en), .msi_addr_i(MSI_ADDR), .msi_data_i(MSI_DATA),
        .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_addr_i(tbl_addr),
        .tbl_data_i(tbl_data), .tbl_mask_i(tbl_mask), .msg_valid_o(msg_valid),
        .msg_ready_i(msg_ready), .msg_type_o(msg_type), .msg_addr_o(msg_addr),
        .msg_data_o(msg_data)
    );

    int n_chk = 0, n_bad = 0, rcnt = 0, ready_pct = 100;
    bit done = 1'b0;
    logic [1:0]    r_type [512];
    logic [AW-1:0] r_addr [512];
    logic [DW-1:0] r_data [512];
    bit            stalled = 1'b0;
    logic [65:0]   held;

    function automatic logic [DW-1:0] f_msi_data(int v);
        return {MSI_DATA[DW-1:VW], 3'(v)};
    endfunction
    function automatic logic [AW-1:0] f_tab_addr(int v);
        return 32'hA000_0000 + 32'(v << 4);
    endfunction
    function automatic logic [DW-1:0] f_tab_data(int v);
        return 32'hD000_0000 + 32'(v);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // consumer: random ready, record accepted messages, check hold while stalled
    always @(negedge clk) begin
        if (!rst_n) begin
            stalled = 1'b0;
        end else begin
            if (stalled)
                chk(msg_valid && {msg_type, msg_addr, msg_data} == held, "R10",
                    "stalled message changed", {msg_addr, msg_data}, held[63:0]);
            msg_ready = ($urandom_range(99) < ready_pct);
            if (msg_valid && msg_ready) begin
                r_type[rcnt] = msg_type;
                r_addr[rcnt] = msg_addr;
                r_data[rcnt] = msg_data;
                rcnt++;
            end
            stalled = msg_valid && !msg_ready;
            held    = {msg_type, msg_addr, msg_data};
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_msgs(int target, int limit);
        for (int i = 0; i < limit && rcnt < target; i++) @(negedge clk);
    endtask

    task automatic chk_msg(int i, logic [1:0] t, logic [AW-1:0] a, logic [DW-1:0] d, string req);
        chk(r_type[i] == t, req, "type", 64'(r_type[i]), 64'(t));
        chk(r_addr[i] == a && r_data[i] == d, req, "addr/data",
            {r_addr[i], r_data[i]}, {a, d});
    endtask

    task automatic pulse(logic [NVEC-1:0] m);
        @(negedge clk) vec_req = m;
        @(negedge clk) vec_req = '0;
    endtask

    task automatic tbl_write(int v, bit m);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 3'(v); tbl_addr = f_tab_addr(v);
        tbl_data = f_tab_data(v); tbl_mask = m;
        @(negedge clk) tbl_we = 1'b0;
    endtask

    task automatic random_rounds(int rounds, bit table_mode);
        for (int r = 0; r < rounds; r++) begin
            logic [NVEC-1:0] m;
            int b, k;
            m = NVEC'($urandom_range(1, 255));
            b = rcnt;
            ready_pct = 50;
            pulse(m);
            wait_msgs(b + $countones(m), 300);
            idle(5);
            chk(rcnt == b + $countones(m), "R9", "burst count", 64'(rcnt - b), 64'($countones(m)));
            k = b;
            for (int v = 0; v < NVEC; v++) begin
                if (m[v] && k < rcnt) begin
                    if (table_mode) chk_msg(k, 2'd2, f_tab_addr(v), f_tab_data(v), "R7");
                    else            chk_msg(k, 2'd2, MSI_ADDR, f_msi_data(v), "R6");
                    k++;
                end
            end
        end
        ready_pct = 100;
    endtask

    initial begin
        int b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!msg_valid, "R1", "valid in reset", 64'(msg_valid), 0);
        rst_n = 1'b1;
        idle(5);
        chk(!msg_valid && rcnt == 0, "R1", "idle after reset", 64'(rcnt), 0);

        // legacy: vector 5 and vector 1 share line 1
        b = rcnt;
        @(negedge clk) vec_req[5] = 1'b1;
        idle(8);
        chk(rcnt == b + 1, "R2", "assert count", 64'(rcnt - b), 1);
        chk_msg(b, 2'd0, '0, 32'd1, "R2");
        @(negedge clk) vec_req[1] = 1'b1;
        idle(8);
        @(negedge clk) vec_req[5] = 1'b0;
        idle(8);
        chk(rcnt == b + 1, "R2", "shared line no message", 64'(rcnt - b), 1);
        @(negedge clk) vec_req[1] = 1'b0;
        idle(8);
        chk(rcnt == b + 2, "R2", "deassert count", 64'(rcnt - b), 2);
        chk_msg(b + 1, 2'd1, '0, 32'd1, "R2");

        // two lines at once: lower line first
        b = rcnt;
        @(negedge clk) vec_req = 8'b0000_1100;
        idle(8);
        chk(rcnt == b + 2, "R9", "legacy pair count", 64'(rcnt - b), 2);
        chk_msg(b, 2'd0, '0, 32'd2, "R9");
        chk_msg(b + 1, 2'd0, '0, 32'd3, "R9");

        // mode switch and vector rise in the same cycle, consumer stalled
        b = rcnt;
        ready_pct = 0;
        @(negedge clk) begin msi_en = 1'b1; vec_req[0] = 1'b1; end
        @(negedge clk) vec_req[0] = 1'b0;
        idle(6);
        ready_pct = 100;
        idle(10);
        chk(rcnt == b + 3, "R5", "switch message count", 64'(rcnt - b), 3);
        chk_msg(b, 2'd1, '0, 32'd2, "R5");
        chk_msg(b + 1, 2'd1, '0, 32'd3, "R5");
        chk_msg(b + 2, 2'd2, MSI_ADDR, f_msi_data(0), "R5");

        // legacy level changes ignored in message mode
        b = rcnt;
        @(negedge clk) vec_req = '0;
        idle(6);
        @(negedge clk) vec_req = 8'b0100_0000;
        idle(6);
        chk(rcnt == b + 1, "R4", "only memwr for rise", 64'(rcnt - b), 1);
        chk(r_type[b] == 2'd2, "R4", "no assert in message mode", 64'(r_type[b]), 2);
        @(negedge clk) vec_req = '0;
        idle(6);
        chk(rcnt == b + 1, "R4", "fall ignored", 64'(rcnt - b), 1);

        // single-address mode, two vectors in one cycle
        b = rcnt;
        pulse(8'b0100_0001);
        idle(8);
        chk(rcnt == b + 2, "R6", "msi pair count", 64'(rcnt - b), 2);
        chk_msg(b, 2'd2, MSI_ADDR, f_msi_data(0), "R6");
        chk_msg(b + 1, 2'd2, MSI_ADDR, f_msi_data(6), "R9");

        // no deassert without a prior assert
        b = rcnt;
        @(negedge clk) msi_en = 1'b0;
        idle(8);
        @(negedge clk) msi_en = 1'b1;
        idle(8);
        chk(rcnt == b, "R3", "no spurious deassert", 64'(rcnt - b), 0);

        // table mode
        for (int v = 0; v < NVEC; v++) tbl_write(v, 1'b0);
        @(negedge clk) msix_en = 1'b1;
        b = rcnt;
        pulse(8'b0000_1000);
        idle(8);
        chk(rcnt == b + 1, "R7", "table count", 64'(rcnt - b), 1);
        chk_msg(b, 2'd2, f_tab_addr(3), f_tab_data(3), "R7");

        // mask holds vector 2, vector 5 passes
        tbl_write(2, 1'b1);
        b = rcnt;
        pulse(8'b0010_0100);
        idle(20);
        chk(rcnt == b + 1, "R8", "masked held", 64'(rcnt - b), 1);
        chk_msg(b, 2'd2, f_tab_addr(5), f_tab_data(5), "R8");
        tbl_write(2, 1'b0);
        idle(8);
        chk(rcnt == b + 2, "R8", "released after unmask", 64'(rcnt - b), 2);
        chk_msg(b + 1, 2'd2, f_tab_addr(2), f_tab_data(2), "R8");

        random_rounds(15, 1'b1);
        @(negedge clk) msix_en = 1'b0;
        random_rounds(15, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule